// File: doc/BRIEF.md
# Paged Coefficient Register Bank

The block stores the 32-bit two's complement coefficients of a chain of second-order filter sections and makes them available to a byte-wide control port. A serial front end (I2C or SPI) drives that port. It opens a transaction by presenting a start address, then issues a stream of byte writes or byte reads. The internal pointer advances after every byte, so one burst can cover many coefficients.

Coefficients live on a contiguous range of pages. Byte 0x00 of every page selects the page. When a burst runs past the top byte of a coefficient page, the pointer continues at the first coefficient byte of the following page. From the last coefficient page it returns to the first one.

A word is written only once all four of its bytes arrive in one burst, most significant byte first. Reading the most significant byte captures the whole word, so the other three bytes of that read always belong to the same value. In SPI mode each read transaction begins with one filler byte. Every stored word also drives a parallel output that the filter datapath reads.

Top module: `coef_bank`

## Requirements
- R1: After reset the page register is 0, `cp_rvalid` is 0, `cp_rdata` is 0x00. The N0 word of every section is 0x7FFFFFFF and its N1, N2, D1 and D2 words are 0.
- R2: On pages 2 to 4, bytes 0x08 to 0x7F hold six sections per page, each 20 bytes long. Within a section the words are N0, N1, N2, D1, D2, each with its most significant byte at the lowest address. The section index is (page-2)*6 + (addr-8)/20. For example, page 3 address 0x30 is section 8 N0 and 0x44 is section 9 N0.
- R3: Address 0x00 on any page reads back the page register. Writing that address loads the page register.
- R4: Each write or non-filler read advances the pointer by one. From 0x7F on a coefficient page the pointer moves to 0x08 on the next page, and from 0x7F on page 4 it moves to 0x08 on page 2. The page register follows the pointer. From 0x7F on any other page the pointer moves to 0x00 of the same page.
- R5: A word changes only on the write of its least significant byte. That write must come directly after writes to its bytes 0, 1 and 2 in the same burst. The new value appears on `coef_o` in the cycle after that write, and earlier bytes do not change it.
- R6: A new start, or any write that is not the next expected byte of the staged word, discards the staged bytes. The word is then left unchanged.
- R7: A read of a word's most significant byte captures the whole word. Later reads of bytes 1 to 3 of that same word return the captured value, even if the word has been rewritten since.
- R8: Addresses 0x01 to 0x07 of a coefficient page, and every nonzero address of any other page, read as 0x00. Writes to them change no stored word.
- R9: If `spi_mode` is 1 when a transaction starts, its first read returns 0x00 and does not move the pointer.
- R10: `cp_rdata` carries the read byte with `cp_rvalid` high in the cycle after `cp_rd`. `cp_rvalid` is low in the cycle after a non-read operation.
- R11: `coef_o[b][s]` is the stored word of section b, slot s (0 = N0, 1 = N1, 2 = N2, 3 = D1, 4 = D2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_mode | input | 1 | Read transactions begin with a filler byte |
| cp_start | input | 1 | Load the pointer from `cp_addr` and begin a transaction |
| cp_addr | input | 8 | Start address within the current page |
| cp_wr | input | 1 | Byte write strobe |
| cp_wdata | input | 8 | Write byte |
| cp_rd | input | 1 | Byte read strobe |
| cp_rdata | output | 8 | Read byte, registered |
| cp_rvalid | output | 1 | `cp_rdata` holds the byte of the previous read |
| coef_o | output | 18x5x32 | Stored coefficient words by section and slot |

## Verification
The assertions assume that at most one of `cp_start`, `cp_wr` and `cp_rd` is high in any cycle, and that `spi_mode` is steady while a start is presented. The stimulus drives only one operation per cycle and then releases it, and it changes `spi_mode` only between transactions. Random bursts target word-aligned and misaligned starts on the coefficient pages, so wrap-around and partial sequences occur naturally. Directed cases cover the page register, wrapping on non-coefficient pages, unmapped addresses and the read capture.

// File: rtl/coef_bank_pkg.sv
package coef_bank_pkg;
  localparam int BYTE_W         = 8;
  localparam int WORD_W         = 32;
  localparam int COEF_PER_BQ    = 5;
  localparam int BYTES_PER_WORD = 4;
  localparam int BQ_BYTES       = COEF_PER_BQ * BYTES_PER_WORD;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;

  localparam word_t UNITY_GAIN    = 32'h7FFF_FFFF;
  localparam byte_t PAGE_SEL_ADDR = 8'h00;

  function automatic byte_t word_byte(input word_t w, input logic [1:0] sel);
    case (sel)
      2'd0:    return w[31:24];
      2'd1:    return w[23:16];
      2'd2:    return w[15:8];
      default: return w[7:0];
    endcase
  endfunction
endpackage

// File: rtl/cb_decode.sv
module cb_decode
  import coef_bank_pkg::*;
#(
  parameter int FIRST_PAGE  = 2,
  parameter int LAST_PAGE   = 4,
  parameter int BASE_OFS    = 8,
  parameter int TOP_ADDR    = 127,
  parameter int BQ_PER_PAGE = 6,
  parameter int IDXW        = 7
) (
  input  byte_t           page,
  input  byte_t           addr,
  output logic            hit,
  output logic [IDXW-1:0] widx,
  output logic [1:0]      bsel
);
  localparam byte_t FIRST_P = byte_t'(FIRST_PAGE);
  localparam byte_t LAST_P  = byte_t'(LAST_PAGE);
  localparam byte_t BASE_P  = byte_t'(BASE_OFS);
  localparam byte_t TOP_P   = byte_t'(TOP_ADDR);

  int off, bq, rem, pg;

  always_comb begin
    off  = int'(addr) - BASE_OFS;
    pg   = int'(page) - FIRST_PAGE;
    bq   = off / BQ_BYTES;
    rem  = off % BQ_BYTES;
    hit  = (page >= FIRST_P) && (page <= LAST_P) &&
           (addr >= BASE_P) && (addr <= TOP_P) && (bq < BQ_PER_PAGE);
    widx = hit ? IDXW'((pg * BQ_PER_PAGE + bq) * COEF_PER_BQ + rem / BYTES_PER_WORD) : '0;
    bsel = 2'(rem % BYTES_PER_WORD);
  end
endmodule

// File: rtl/cb_pointer.sv
module cb_pointer
  import coef_bank_pkg::*;
#(
  parameter int FIRST_PAGE = 2,
  parameter int LAST_PAGE  = 4,
  parameter int BASE_OFS   = 8,
  parameter int TOP_ADDR   = 127
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  spi_mode,
  input  logic  start,
  input  byte_t addr_in,
  input  logic  wr,
  input  byte_t wdata,
  input  logic  rd,
  output byte_t cur_page,
  output byte_t cur_addr,
  output logic  acc_wr,
  output logic  acc_rd,
  output logic  dummy_rd
);
  localparam byte_t FIRST_P = byte_t'(FIRST_PAGE);
  localparam byte_t LAST_P  = byte_t'(LAST_PAGE);
  localparam byte_t BASE_P  = byte_t'(BASE_OFS);
  localparam byte_t TOP_P   = byte_t'(TOP_ADDR);

  logic  dummy_pend;
  logic  on_coef;
  byte_t nxt_addr, nxt_page;

  assign acc_wr   = wr & ~start;
  assign acc_rd   = rd & ~start & ~dummy_pend;
  assign dummy_rd = rd & ~start & dummy_pend;
  assign on_coef  = (cur_page >= FIRST_P) && (cur_page <= LAST_P);

  always_comb begin
    nxt_addr = cur_addr + 8'd1;
    nxt_page = cur_page;
    if (cur_addr == TOP_P) begin
      if (on_coef) begin
        nxt_addr = BASE_P;
        nxt_page = (cur_page == LAST_P) ? FIRST_P : cur_page + 8'd1;
      end else begin
        nxt_addr = 8'h00;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_page   <= 8'h00;
      cur_addr   <= 8'h00;
      dummy_pend <= 1'b0;
    end else if (start) begin
      cur_addr   <= addr_in;
      dummy_pend <= spi_mode;
    end else begin
      if (dummy_rd) dummy_pend <= 1'b0;
      if (acc_wr || acc_rd) begin
        cur_addr <= nxt_addr;
        cur_page <= nxt_page;
      end
      if (acc_wr && cur_addr == PAGE_SEL_ADDR) cur_page <= wdata;
    end
  end

  AST_WRAP_TO_BASE: assert property (@(posedge clk) disable iff (rst)
    ((acc_wr || acc_rd) && cur_addr == TOP_P && on_coef) |=> (cur_addr == BASE_P)); // R4
  AST_LAST_PAGE_ROLL: assert property (@(posedge clk) disable iff (rst)
    ((acc_wr || acc_rd) && cur_addr == TOP_P && cur_page == LAST_P) |=> (cur_page == FIRST_P)); // R4
  AST_DUMMY_HOLD: assert property (@(posedge clk) disable iff (rst)
    dummy_rd |=> $stable(cur_addr)); // R9
endmodule

// File: rtl/cb_stager.sv
module cb_stager
  import coef_bank_pkg::*;
#(
  parameter int IDXW = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            acc_wr,
  input  logic            hit,
  input  logic [IDXW-1:0] widx,
  input  logic [1:0]      bsel,
  input  byte_t           wdata,
  output logic            commit,
  output logic [IDXW-1:0] commit_idx,
  output word_t           commit_word
);
  logic            stg_valid;
  logic [1:0]      stg_next;
  logic [IDXW-1:0] stg_idx;
  logic [23:0]     stg_data;
  logic            in_seq;

  assign in_seq      = stg_valid && hit && (stg_next == bsel) && (stg_idx == widx);
  assign commit      = acc_wr && in_seq && (bsel == 2'd3);
  assign commit_idx  = stg_idx;
  assign commit_word = {stg_data, wdata};

  always_ff @(posedge clk) begin
    if (rst || start) begin
      stg_valid <= 1'b0;
      stg_next  <= 2'd0;
      stg_idx   <= '0;
      stg_data  <= '0;
    end else if (acc_wr) begin
      if (hit && bsel == 2'd0) begin
        stg_valid       <= 1'b1;
        stg_next        <= 2'd1;
        stg_idx         <= widx;
        stg_data[23:16] <= wdata;
      end else if (in_seq && bsel != 2'd3) begin
        stg_next <= stg_next + 2'd1;
        if (bsel == 2'd1) stg_data[15:8] <= wdata;
        else              stg_data[7:0]  <= wdata;
      end else begin
        stg_valid <= 1'b0;
      end
    end
  end

  AST_START_DISCARDS: assert property (@(posedge clk) disable iff (rst)
    start |=> !commit); // R6
endmodule

// File: rtl/cb_store.sv
module cb_store
  import coef_bank_pkg::*;
#(
  parameter int NUM_BQ    = 18,
  parameter int NUM_WORDS = 90,
  parameter int IDXW      = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            commit,
  input  logic [IDXW-1:0] commit_idx,
  input  word_t           commit_word,
  input  logic            acc_rd,
  input  logic            dummy_rd,
  input  logic            hit,
  input  logic [IDXW-1:0] widx,
  input  logic [1:0]      bsel,
  input  byte_t           cur_page,
  input  byte_t           cur_addr,
  output byte_t           rdata,
  output logic            rvalid,
  output logic [NUM_BQ-1:0][COEF_PER_BQ-1:0][WORD_W-1:0] coef_o
);
  word_t           bank [NUM_WORDS];
  word_t           snap;
  logic [IDXW-1:0] snap_idx;
  logic            snap_v;
  word_t           src;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_WORDS; i++)
        bank[i] <= (i % COEF_PER_BQ == 0) ? UNITY_GAIN : '0;
    end else if (commit) begin
      bank[commit_idx] <= commit_word;
    end
  end

  for (genvar b = 0; b < NUM_BQ; b++) begin : g_bq
    for (genvar s = 0; s < COEF_PER_BQ; s++) begin : g_slot
      assign coef_o[b][s] = bank[b * COEF_PER_BQ + s];
    end
  end

  assign src = (snap_v && snap_idx == widx) ? snap : bank[widx];

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rvalid   <= 1'b0;
      snap     <= '0;
      snap_idx <= '0;
      snap_v   <= 1'b0;
    end else begin
      rvalid <= acc_rd | dummy_rd;
      if (dummy_rd) begin
        rdata <= '0;
      end else if (acc_rd) begin
        if (cur_addr == PAGE_SEL_ADDR) begin
          rdata <= cur_page;
        end else if (hit && bsel == 2'd0) begin
          rdata    <= word_byte(bank[widx], 2'd0);
          snap     <= bank[widx];
          snap_idx <= widx;
          snap_v   <= 1'b1;
        end else if (hit) begin
          rdata <= word_byte(src, bsel);
        end else begin
          rdata <= '0;
        end
      end
    end
  end

  AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (acc_rd || dummy_rd) |=> rvalid); // R10
  AST_DUMMY_ZERO: assert property (@(posedge clk) disable iff (rst)
    dummy_rd |=> (rdata == 8'h00)); // R9
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    hit |-> (int'(widx) < NUM_WORDS)); // R2
endmodule

// File: rtl/coef_bank.sv
module coef_bank
  import coef_bank_pkg::*;
#(
  parameter  int FIRST_PAGE  = 2,
  parameter  int NUM_PAGES   = 3,
  parameter  int BASE_OFS    = 8,
  parameter  int TOP_ADDR    = 127,
  localparam int LAST_PAGE   = FIRST_PAGE + NUM_PAGES - 1,
  localparam int BQ_PER_PAGE = (TOP_ADDR - BASE_OFS + 1) / BQ_BYTES,
  localparam int NUM_BQ      = NUM_PAGES * BQ_PER_PAGE,
  localparam int NUM_WORDS   = NUM_BQ * COEF_PER_BQ,
  localparam int IDXW        = $clog2(NUM_WORDS)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        spi_mode,
  input  logic        cp_start,
  input  logic [7:0]  cp_addr,
  input  logic        cp_wr,
  input  logic [7:0]  cp_wdata,
  input  logic        cp_rd,
  output logic [7:0]  cp_rdata,
  output logic        cp_rvalid,
  output logic [NUM_BQ-1:0][COEF_PER_BQ-1:0][WORD_W-1:0] coef_o
);
  byte_t           cur_page, cur_addr;
  logic            acc_wr, acc_rd, dummy_rd;
  logic            hit;
  logic [IDXW-1:0] widx;
  logic [1:0]      bsel;
  logic            commit;
  logic [IDXW-1:0] commit_idx;
  word_t           commit_word;

  cb_pointer #(
    .FIRST_PAGE(FIRST_PAGE), .LAST_PAGE(LAST_PAGE),
    .BASE_OFS(BASE_OFS), .TOP_ADDR(TOP_ADDR)
  ) u_pointer (
    .clk(clk), .rst(rst), .spi_mode(spi_mode), .start(cp_start),
    .addr_in(cp_addr), .wr(cp_wr), .wdata(cp_wdata), .rd(cp_rd),
    .cur_page(cur_page), .cur_addr(cur_addr),
    .acc_wr(acc_wr), .acc_rd(acc_rd), .dummy_rd(dummy_rd)
  );

  cb_decode #(
    .FIRST_PAGE(FIRST_PAGE), .LAST_PAGE(LAST_PAGE), .BASE_OFS(BASE_OFS),
    .TOP_ADDR(TOP_ADDR), .BQ_PER_PAGE(BQ_PER_PAGE), .IDXW(IDXW)
  ) u_decode (
    .page(cur_page), .addr(cur_addr), .hit(hit), .widx(widx), .bsel(bsel)
  );

  cb_stager #(.IDXW(IDXW)) u_stager (
    .clk(clk), .rst(rst), .start(cp_start), .acc_wr(acc_wr),
    .hit(hit), .widx(widx), .bsel(bsel), .wdata(cp_wdata),
    .commit(commit), .commit_idx(commit_idx), .commit_word(commit_word)
  );

  cb_store #(.NUM_BQ(NUM_BQ), .NUM_WORDS(NUM_WORDS), .IDXW(IDXW)) u_store (
    .clk(clk), .rst(rst), .commit(commit), .commit_idx(commit_idx),
    .commit_word(commit_word), .acc_rd(acc_rd), .dummy_rd(dummy_rd),
    .hit(hit), .widx(widx), .bsel(bsel), .cur_page(cur_page),
    .cur_addr(cur_addr), .rdata(cp_rdata), .rvalid(cp_rvalid), .coef_o(coef_o)
  );

  AST_QUIET_BANK: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(coef_o)); // R5
  AST_NO_RVALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !cp_rd |=> !cp_rvalid); // R10
endmodule

// File: tb/coef_bank_bench.sv
module coef_bank_bench;
  localparam int NBQ = 18;
  localparam int NW  = NBQ * 5;

  logic        clk = 1'b0;
  logic        rst, spi_mode, cp_start, cp_wr, cp_rd, cp_rvalid;
  logic [7:0]  cp_addr, cp_wdata, cp_rdata;
  logic [NBQ-1:0][4:0][31:0] coef;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_mem [NW];
  logic [7:0]  m_pg, m_ad;
  int          m_cnt, m_sidx, m_snidx;
  logic [23:0] m_stg;
  logic [31:0] m_snap;
  bit          m_dum;

  always #5 clk = ~clk;

  coef_bank u_coef_bank (
    .clk(clk), .rst(rst), .spi_mode(spi_mode), .cp_start(cp_start),
    .cp_addr(cp_addr), .cp_wr(cp_wr), .cp_wdata(cp_wdata), .cp_rd(cp_rd),
    .cp_rdata(cp_rdata), .cp_rvalid(cp_rvalid), .coef_o(coef)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void dec(input logic [7:0] pg, input logic [7:0] ad,
                              output bit hit, output int idx, output int by);
    int off;
    hit = 0; idx = 0; by = 0;
    if (pg >= 2 && pg <= 4 && ad >= 8 && ad <= 127) begin
      off = int'(ad) - 8;
      hit = 1;
      idx = ((int'(pg) - 2) * 6 + off / 20) * 5 + (off % 20) / 4;
      by  = off % 4;
    end
  endfunction

  function automatic void adv();
    if (m_ad == 8'h7F) begin
      if (m_pg >= 2 && m_pg <= 4) begin
        m_ad = 8'h08;
        m_pg = (m_pg == 4) ? 8'd2 : m_pg + 8'd1;
      end else m_ad = 8'h00;
    end else m_ad = m_ad + 8'd1;
  endfunction

  task automatic op_start(input logic [7:0] a);
    cp_start = 1'b1; cp_addr = a;
    @(negedge clk);
    cp_start = 1'b0;
    m_ad = a; m_cnt = -1; m_dum = spi_mode;
  endtask

  task automatic op_wr(input logic [7:0] d);
    bit h; int idx, by;
    cp_wr = 1'b1; cp_wdata = d;
    @(negedge clk);
    cp_wr = 1'b0;
    dec(m_pg, m_ad, h, idx, by);
    if (m_ad == 8'h00) begin
      m_pg = d; m_cnt = -1;
    end else if (h && by == 0) begin
      m_stg[23:16] = d; m_cnt = 1; m_sidx = idx;
    end else if (h && by == m_cnt && idx == m_sidx) begin
      if (by == 3) begin m_mem[idx] = {m_stg, d}; m_cnt = -1; end
      else begin m_stg[23 - 8*by -: 8] = d; m_cnt++; end
    end else m_cnt = -1;
    adv();
  endtask

  task automatic op_rd(input string req);
    bit h; int idx, by;
    logic [7:0]  exp;
    logic [31:0] w;
    if (m_dum) begin
      exp = 8'h00; m_dum = 0;
    end else begin
      dec(m_pg, m_ad, h, idx, by);
      if (m_ad == 8'h00) exp = m_pg;
      else if (h && by == 0) begin
        m_snap = m_mem[idx]; m_snidx = idx; exp = m_snap[31:24];
      end else if (h) begin
        w = (m_snidx == idx) ? m_snap : m_mem[idx];
        exp = w[31 - 8*by -: 8];
      end else exp = 8'h00;
      adv();
    end
    cp_rd = 1'b1;
    @(negedge clk);
    cp_rd = 1'b0;
    chk(req, {23'd0, cp_rvalid, cp_rdata}, {23'd0, 1'b1, exp});
  endtask

  task automatic chk_all(input string req);
    int bad = 0;
    for (int b = 0; b < NBQ; b++)
      for (int s = 0; s < 5; s++)
        if (coef[b][s] !== m_mem[b*5 + s]) bad++;
    chk(req, bad, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; spi_mode = 1'b0; cp_start = 1'b0; cp_wr = 1'b0; cp_rd = 1'b0;
    cp_addr = 8'h00; cp_wdata = 8'h00;
    for (int i = 0; i < NW; i++) m_mem[i] = (i % 5 == 0) ? 32'h7FFF_FFFF : 32'h0;
    m_pg = 0; m_ad = 0; m_cnt = -1; m_sidx = 0; m_snidx = -1; m_stg = 0; m_snap = 0; m_dum = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    chk("R1", {23'd0, cp_rvalid, cp_rdata}, 32'd0);
    chk_all("R1");
    chk("R1", coef[8][0], 32'h7FFF_FFFF);
    chk("R1", coef[8][1], 32'h0);

    // R3 page register
    op_start(8'h00); op_rd("R3");
    op_start(8'h00); op_wr(8'h03);
    chk("R10", {31'd0, cp_rvalid}, 32'd0);
    op_start(8'h00); op_rd("R3");
    chk("R3", cp_rdata, 8'h03);

    // R2 layout on page 3
    op_start(8'h30);
    for (int i = 0; i < 4; i++) op_rd("R2");
    chk("R2", cp_rdata, 8'hFF);
    op_start(8'h44); op_rd("R2");
    chk("R2", cp_rdata, 8'h7F);
    op_start(8'h48); op_rd("R2");
    chk("R2", cp_rdata, 8'h00);

    // R5 commit on byte 4 only; R11 output index
    op_start(8'h34);
    op_wr(8'h12); op_wr(8'h34); op_wr(8'h56);
    chk("R5", coef[8][1], 32'h0);
    op_wr(8'h78);
    chk("R5", coef[8][1], 32'h1234_5678);
    chk("R11", coef[8][1], m_mem[41]);

    // R6 partial and out-of-order sequences
    op_start(8'h38); op_wr(8'h01); op_wr(8'h02); op_wr(8'h03);
    op_start(8'h3B); op_wr(8'h04);
    chk("R6", coef[8][2], 32'h0);
    op_start(8'h39); op_wr(8'h05); op_wr(8'h06); op_wr(8'h07);
    chk("R6", coef[8][2], 32'h0);

    // R7 read capture
    op_start(8'h34); op_rd("R7");
    op_start(8'h34); op_wr(8'hAA); op_wr(8'hBB); op_wr(8'hCC); op_wr(8'hDD);
    chk("R7", coef[8][1], 32'hAABB_CCDD);
    op_start(8'h35); op_rd("R7"); op_rd("R7"); op_rd("R7");
    chk("R7", cp_rdata, 8'h78);
    op_start(8'h34); op_rd("R7");
    chk("R7", cp_rdata, 8'hAA);

    // R4 page crossing
    op_start(8'h7C);
    op_wr(8'h01); op_wr(8'h02); op_wr(8'h03); op_wr(8'h04);
    op_wr(8'h05); op_wr(8'h06); op_wr(8'h07); op_wr(8'h08);
    chk("R4", coef[11][4], 32'h0102_0304);
    chk("R4", coef[12][0], 32'h0506_0708);
    op_start(8'h00); op_rd("R4");
    chk("R4", cp_rdata, 8'h04);
    op_start(8'h7F); op_rd("R4"); op_rd("R4");
    chk("R4", cp_rdata, 8'h7F);
    op_start(8'h00); op_rd("R4");
    chk("R4", cp_rdata, 8'h02);
    op_start(8'h00); op_wr(8'h09);
    op_start(8'h7F); op_rd("R4"); op_rd("R4");
    chk("R4", cp_rdata, 8'h09);

    // R8 unmapped space
    op_start(8'h30); op_wr(8'h55); op_wr(8'h66);
    op_start(8'h30); op_rd("R8");
    chk("R8", cp_rdata, 8'h00);
    op_start(8'h00); op_wr(8'h03);
    op_start(8'h05); op_wr(8'h66);
    op_start(8'h05); op_rd("R8");
    chk("R8", cp_rdata, 8'h00);
    chk_all("R8");

    // R9 filler byte in SPI mode
    spi_mode = 1'b1;
    op_start(8'h30); op_rd("R9");
    chk("R9", cp_rdata, 8'h00);
    op_rd("R9");
    chk("R9", cp_rdata, 8'h7F);
    op_rd("R9"); op_rd("R9"); op_rd("R9");
    spi_mode = 1'b0;

    // random bursts
    for (int n = 0; n < 300; n++) begin
      logic [7:0] a;
      int k;
      spi_mode = ($urandom % 4) == 0;
      op_start(8'h00); op_wr(8'(2 + $urandom % 3));
      a = 8'(8 + ($urandom % 30) * 4);
      if ($urandom % 5 == 0) a = a + 8'($urandom % 4);
      op_start(a);
      k = 1 + $urandom % 9;
      for (int j = 0; j < k; j++) op_wr(8'($urandom));
      chk_all("R5");
      op_start(a & 8'hFC);
      k = $urandom % 10;
      for (int j = 0; j < k; j++) op_rd("R2");
    end
    spi_mode = 1'b0;
    chk_all("R11");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule